// File: doc/BRIEF.md
# Two-Way Set-Associative Byte Cache with Run-Time Write Policy

This block sits between a processor port that reads and writes single bytes and a main-memory port that moves whole blocks. A byte address is divided into three fields. The low bits give the byte within a block, the middle bits choose a set, and the high bits form the tag. Each set has two ways. Both tags of the chosen set are compared at once. A hit is answered from the line storage without touching memory. A miss fetches the whole block, installs it in the least recently used way and returns the requested byte from the fetched data.

Two control inputs are sampled when each access is accepted. One of them bypasses the cache completely, so the access goes straight to memory. The other chooses between write-back and write-through. In write-back mode, write hits stay in the cache and mark the line modified. A modified victim is copied out before its way is refilled. In write-through mode, every write also reaches memory, and a write miss does not allocate a line.

Top module: `cache_2way`

## Requirements
- R1: The byte offset is `cpu_addr[OFFS_W-1:0]`, the set index is the next `SETS_W` bits, and the tag is the remaining upper bits. Blocks with different set fields never displace each other.
- R2: A read hit with the cache enabled raises `cpu_ready` in the cycle after the request is accepted, returns the stored byte and issues no memory request.
- R3: A read miss issues exactly one memory read at block address `cpu_addr[ADDR_W-1:OFFS_W]`. It returns byte `cpu_addr[OFFS_W-1:0]` of the fetched block and installs the block.
- R4: Each set keeps one recency bit, and every hit or fill sets it to the way that was not used. On a miss, the way named by this bit is replaced.
- R5: A write hit in write-back mode (`ctl_wback`=1) updates only the cached byte, marks the line modified and makes no memory access.
- R6: Before a modified victim is refilled, its whole block is written to memory with all byte enables set. A clean victim causes no memory write.
- R7: Every write in write-through mode (`ctl_wback`=0) makes one memory write. That write has only enable bit `cpu_addr[OFFS_W-1:0]` set and carries the byte repeated in every lane. On a hit, the cached byte is updated as well.
- R8: A write miss in write-through mode does not allocate a line, so a later read of that block misses.
- R9: A write miss in write-back mode first fetches the block, then merges the byte and installs the line as modified.
- R10: With `ctl_disable`=1, each access makes one memory transfer at the block address (reads return the addressed byte, writes use one byte enable). Tags, valid bits, modified bits and recency bits are left unchanged.
- R11: After reset, every line is invalid and unmodified, so the first access to any block misses.
- R12: `mem_req` stays high, with a stable address and direction, until `mem_ready` is seen. `cpu_ready` is a single-cycle pulse, and both are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_disable | input | 1 | 1: bypass the cache for this access |
| ctl_wback | input | 1 | 1: write-back, 0: write-through |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1: write, 0: read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access complete, one-cycle pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1: block write, 0: block read |
| mem_addr | output | ADDR_W-OFFS_W | Block address |
| mem_be | output | 2**OFFS_W | Byte enables for writes |
| mem_wdata | output | 8*2**OFFS_W | Write block |
| mem_rdata | input | 8*2**OFFS_W | Read block, valid with `mem_ready` |
| mem_ready | input | 1 | Memory transfer complete, one-cycle pulse |

## Verification
The bench uses `ADDR_W`=24, `OFFS_W`=2 and `SETS_W`=2. With only four sets, a few small addresses in set 0 are enough to fill both ways, evict a clean victim, evict a modified victim and bring the evicted data back from memory. Several blocks that differ only in tag also make the recency bit's victim choice visible through memory-transfer counts. The memory model answers after a fixed delay, and its transfer counters show every hit, fill, write-back and write-through at the ports.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WORD  = 3'd1,
    ST_EVICT = 3'd2,
    ST_FILL  = 3'd3,
    ST_DONE  = 3'd4
  } cstate_e;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int SETS_W = 6,
  parameter int TAG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SETS_W-1:0] set_idx,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic              sel_way,
  output logic              hit,
  output logic              hit_way,
  output logic              lru_way,
  output logic              vic_dirty,
  output logic [TAG_W-1:0]  sel_tag,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              fill_dirty,
  input  logic              mark_dirty_en,
  input  logic              touch_en,
  input  logic              touch_way
);
  localparam int SETS = 1 << SETS_W;
  localparam int WAYS = 2;

  logic [WAYS-1:0]             match;
  logic [WAYS-1:0]             way_vld;
  logic [WAYS-1:0]             way_dty;
  logic [WAYS-1:0][TAG_W-1:0]  way_tag;
  logic [SETS-1:0]             lru_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  dty_q;
    logic             this_sel;

    assign this_sel   = (sel_way == 1'(w));
    assign way_vld[w] = vld_q[set_idx];
    assign way_dty[w] = dty_q[set_idx];
    assign way_tag[w] = tag_q[set_idx];
    assign match[w]   = vld_q[set_idx] && (tag_q[set_idx] == look_tag);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        dty_q <= '0;
      end else if (fill_en && this_sel) begin
        vld_q[set_idx] <= 1'b1;
        dty_q[set_idx] <= fill_dirty;
      end else if (mark_dirty_en && this_sel) begin
        dty_q[set_idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && this_sel) tag_q[set_idx] <= fill_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lru_q <= '0;
    else if (touch_en) lru_q[set_idx] <= ~touch_way;
  end

  assign hit       = |match;
  assign hit_way   = match[1];
  assign lru_way   = lru_q[set_idx];
  assign vic_dirty = way_vld[lru_way] && way_dty[lru_way];
  assign sel_tag   = way_tag[sel_way];

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int SETS_W = 6,
  parameter int LINE_W = 32
) (
  input  logic              clk,
  input  logic [SETS_W-1:0] set_idx,
  input  logic              sel_way,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int SETS = 1 << SETS_W;
  localparam int WAYS = 2;

  logic [WAYS-1:0][LINE_W-1:0] way_line;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [LINE_W-1:0] line_q [SETS];

    assign way_line[w] = line_q[set_idx];

    always_ff @(posedge clk) begin
      if (wr_en && (sel_way == 1'(w))) line_q[set_idx] <= wr_line;
    end
  end

  assign rd_line = way_line[sel_way];

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SETS_W = 6,
  parameter int OFFS_W = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   ctl_disable,
  input  logic                                   ctl_wback,
  input  logic                                   cpu_req,
  input  logic                                   cpu_we,
  input  logic [ADDR_W-1:0]                      cpu_addr,
  input  logic [7:0]                             cpu_wdata,
  output logic [7:0]                             cpu_rdata,
  output logic                                   cpu_ready,
  output logic                                   mem_req,
  output logic                                   mem_we,
  output logic [ADDR_W-OFFS_W-1:0]               mem_addr,
  output logic [(1<<OFFS_W)-1:0]                 mem_be,
  output logic [8*(1<<OFFS_W)-1:0]               mem_wdata,
  input  logic [8*(1<<OFFS_W)-1:0]               mem_rdata,
  input  logic                                   mem_ready,
  output logic [ADDR_W-1:0]                      look_addr,
  input  logic                                   hit,
  input  logic                                   hit_way,
  input  logic                                   lru_way,
  input  logic                                   vic_dirty,
  input  logic [ADDR_W-SETS_W-OFFS_W-1:0]        sel_tag,
  output logic                                   sel_way,
  output logic                                   fill_en,
  output logic                                   fill_dirty,
  output logic                                   mark_dirty_en,
  output logic                                   touch_en,
  output logic                                   touch_way,
  input  logic [8*(1<<OFFS_W)-1:0]               rd_line,
  output logic                                   wr_en,
  output logic [8*(1<<OFFS_W)-1:0]               wr_line,
  output logic                                   idle
);
  localparam int BE_W   = 1 << OFFS_W;
  localparam int LINE_W = 8 * BE_W;
  localparam int TAG_W  = ADDR_W - SETS_W - OFFS_W;
  localparam int BLK_W  = ADDR_W - OFFS_W;

  cstate_e            st_q, st_d;
  logic [ADDR_W-1:0]  addr_q;
  logic               we_q;
  logic [7:0]         wdata_q;
  logic               way_q;
  logic [7:0]         rdata_q;
  logic               accept;
  logic               way_en;
  logic               rdata_en;
  logic [7:0]         rdata_d;
  logic [OFFS_W-1:0]  off;

  function automatic logic [7:0] pick(input logic [LINE_W-1:0] l, input logic [OFFS_W-1:0] o);
    return l[int'(o)*8 +: 8];
  endfunction

  function automatic logic [LINE_W-1:0] merge(input logic [LINE_W-1:0] l, input logic [OFFS_W-1:0] o,
                                              input logic [7:0] b);
    logic [LINE_W-1:0] r;
    r = l;
    r[int'(o)*8 +: 8] = b;
    return r;
  endfunction

  assign idle      = (st_q == ST_IDLE);
  assign accept    = idle && cpu_req;
  assign look_addr = idle ? cpu_addr : addr_q;
  assign off       = look_addr[OFFS_W-1:0];
  assign cpu_ready = (st_q == ST_DONE);
  assign cpu_rdata = rdata_q;

  always_comb begin
    if (idle) sel_way = hit ? hit_way : lru_way;
    else      sel_way = way_q;
  end

  always_comb begin
    st_d          = st_q;
    way_en        = 1'b0;
    rdata_en      = 1'b0;
    rdata_d       = rdata_q;
    fill_en       = 1'b0;
    fill_dirty    = 1'b0;
    mark_dirty_en = 1'b0;
    touch_en      = 1'b0;
    touch_way     = 1'b0;
    wr_en         = 1'b0;
    wr_line       = rd_line;
    mem_req       = 1'b0;
    mem_we        = 1'b0;
    mem_addr      = addr_q[ADDR_W-1:OFFS_W];
    mem_be        = '0;
    mem_wdata     = {BE_W{wdata_q}};
    unique case (st_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (ctl_disable) begin
            st_d = ST_WORD;
          end else if (hit) begin
            touch_en  = 1'b1;
            touch_way = hit_way;
            if (!cpu_we) begin
              rdata_en = 1'b1;
              rdata_d  = pick(rd_line, off);
              st_d     = ST_DONE;
            end else begin
              wr_en   = 1'b1;
              wr_line = merge(rd_line, off, cpu_wdata);
              if (ctl_wback) begin
                mark_dirty_en = 1'b1;
                st_d          = ST_DONE;
              end else begin
                st_d = ST_WORD;
              end
            end
          end else if (cpu_we && !ctl_wback) begin
            st_d = ST_WORD;
          end else begin
            way_en = 1'b1;
            st_d   = vic_dirty ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_WORD: begin
        mem_req = 1'b1;
        mem_we  = we_q;
        mem_be  = we_q ? (BE_W'(1) << off) : '0;
        if (mem_ready) begin
          rdata_en = 1'b1;
          rdata_d  = pick(mem_rdata, off);
          st_d     = ST_DONE;
        end
      end
      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {sel_tag, addr_q[OFFS_W +: SETS_W]};
        mem_be    = '1;
        mem_wdata = rd_line;
        if (mem_ready) st_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ready) begin
          wr_en      = 1'b1;
          wr_line    = we_q ? merge(mem_rdata, off, wdata_q) : mem_rdata;
          fill_en    = 1'b1;
          fill_dirty = we_q;
          touch_en   = 1'b1;
          touch_way  = way_q;
          rdata_en   = 1'b1;
          rdata_d    = pick(mem_rdata, off);
          st_d       = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q  <= cpu_addr;
      we_q    <= cpu_we;
      wdata_q <= cpu_wdata;
    end
    if (way_en)   way_q   <= lru_way;
    if (rdata_en) rdata_q <= rdata_d;
  end

  logic unused_bits;
  assign unused_bits = ^{BLK_W, TAG_W};

endmodule

// File: rtl/cache_2way.sv
module cache_2way #(
  parameter int ADDR_W = 24,
  parameter int SETS_W = 6,
  parameter int OFFS_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctl_disable,
  input  logic                          ctl_wback,
  input  logic                          cpu_req,
  input  logic                          cpu_we,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [7:0]                    cpu_wdata,
  output logic [7:0]                    cpu_rdata,
  output logic                          cpu_ready,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [ADDR_W-OFFS_W-1:0]      mem_addr,
  output logic [(1<<OFFS_W)-1:0]        mem_be,
  output logic [8*(1<<OFFS_W)-1:0]      mem_wdata,
  input  logic [8*(1<<OFFS_W)-1:0]      mem_rdata,
  input  logic                          mem_ready
);
  localparam int BE_W   = 1 << OFFS_W;
  localparam int LINE_W = 8 * BE_W;
  localparam int TAG_W  = ADDR_W - SETS_W - OFFS_W;
  localparam int BLK_W  = ADDR_W - OFFS_W;

  logic [1:0]         rst_sync_q;
  logic               rst_n_int;
  logic [ADDR_W-1:0]  look_addr;
  logic               lkp_hit;
  logic               hit_way;
  logic               lru_way;
  logic               vic_dirty;
  logic [TAG_W-1:0]   sel_tag;
  logic               sel_way;
  logic               fill_en;
  logic               fill_dirty;
  logic               mark_dirty_en;
  logic               touch_en;
  logic               touch_way;
  logic [LINE_W-1:0]  rd_line;
  logic               wr_en;
  logic [LINE_W-1:0]  wr_line;
  logic               ctl_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  cache_tag_store #(.SETS_W(SETS_W), .TAG_W(TAG_W)) i_tags (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .set_idx      (look_addr[OFFS_W +: SETS_W]),
    .look_tag     (look_addr[ADDR_W-1 -: TAG_W]),
    .sel_way      (sel_way),
    .hit          (lkp_hit),
    .hit_way      (hit_way),
    .lru_way      (lru_way),
    .vic_dirty    (vic_dirty),
    .sel_tag      (sel_tag),
    .fill_en      (fill_en),
    .fill_tag     (look_addr[ADDR_W-1 -: TAG_W]),
    .fill_dirty   (fill_dirty),
    .mark_dirty_en(mark_dirty_en),
    .touch_en     (touch_en),
    .touch_way    (touch_way)
  );

  cache_data_store #(.SETS_W(SETS_W), .LINE_W(LINE_W)) i_data (
    .clk    (clk),
    .set_idx(look_addr[OFFS_W +: SETS_W]),
    .sel_way(sel_way),
    .rd_line(rd_line),
    .wr_en  (wr_en),
    .wr_line(wr_line)
  );

  cache_ctrl #(.ADDR_W(ADDR_W), .SETS_W(SETS_W), .OFFS_W(OFFS_W)) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .ctl_disable  (ctl_disable),
    .ctl_wback    (ctl_wback),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdata    (cpu_rdata),
    .cpu_ready    (cpu_ready),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .mem_ready    (mem_ready),
    .look_addr    (look_addr),
    .hit          (lkp_hit),
    .hit_way      (hit_way),
    .lru_way      (lru_way),
    .vic_dirty    (vic_dirty),
    .sel_tag      (sel_tag),
    .sel_way      (sel_way),
    .fill_en      (fill_en),
    .fill_dirty   (fill_dirty),
    .mark_dirty_en(mark_dirty_en),
    .touch_en     (touch_en),
    .touch_way    (touch_way),
    .rd_line      (rd_line),
    .wr_en        (wr_en),
    .wr_line      (wr_line),
    .idle         (ctl_idle)
  );

endmodule

// File: rtl/cache_2way_chk.sv
module cache_2way_chk #(
  parameter int BLK_W = 22,
  parameter int BE_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_disable,
  input logic             ctl_wback,
  input logic             cpu_req,
  input logic             cpu_we,
  input logic             cpu_ready,
  input logic             mem_req,
  input logic             mem_we,
  input logic [BLK_W-1:0] mem_addr,
  input logic [BE_W-1:0]  mem_be,
  input logic             mem_ready,
  input logic             lkp_hit,
  input logic             ctl_idle
);

  AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R12

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready); // R12

  AST_WRITE_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == BE_W)); // R7

  AST_READ_HIT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_idle && cpu_req && !ctl_disable && lkp_hit && !cpu_we |=> cpu_ready && !mem_req); // R2

  AST_WB_HIT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_idle && cpu_req && !ctl_disable && lkp_hit && cpu_we && ctl_wback |=> cpu_ready && !mem_req); // R5

endmodule

bind cache_2way cache_2way_chk #(.BLK_W(BLK_W), .BE_W(BE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_disable(ctl_disable),
  .ctl_wback  (ctl_wback),
  .cpu_req    (cpu_req),
  .cpu_we     (cpu_we),
  .cpu_ready  (cpu_ready),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .mem_ready  (mem_ready),
  .lkp_hit    (lkp_hit),
  .ctl_idle   (ctl_idle)
);

// File: tb/test_cache_2way.sv
`timescale 1ns/1ps
module test_cache_2way;
  localparam int ADDR_W = 24;
  localparam int SETS_W = 2;
  localparam int OFFS_W = 2;
  localparam int BE_W   = 1 << OFFS_W;
  localparam int LINE_W = 8 * BE_W;
  localparam int BLK_W  = ADDR_W - OFFS_W;
  localparam int LAT    = 2;
  localparam int NVEC   = 18;

  typedef struct packed {
    logic [3:0]  req;
    logic        dis;
    logic        wb;
    logic        we;
    logic [23:0] addr;
    logic [7:0]  wdata;
    logic        chk;
    logic [7:0]  exp_rd;
    logic [3:0]  exp_r;
    logic [3:0]  exp_w;
  } vec_t;

  // Set 0 is used by 0x10..0x50, set 1 by 0x64, set 2 by 0x68 (four sets).
  localparam vec_t VEC [NVEC] = '{
    '{4'd3,  1'b0, 1'b1, 1'b0, 24'h000010, 8'h00, 1'b1, 8'h10, 4'd1, 4'd0}, // R3 cold read miss
    '{4'd2,  1'b0, 1'b1, 1'b0, 24'h000011, 8'h00, 1'b1, 8'h11, 4'd0, 4'd0}, // R2 read hit
    '{4'd5,  1'b0, 1'b1, 1'b1, 24'h000012, 8'hAB, 1'b0, 8'h00, 4'd0, 4'd0}, // R5 write-back hit
    '{4'd4,  1'b0, 1'b1, 1'b0, 24'h000020, 8'h00, 1'b1, 8'h20, 4'd1, 4'd0}, // R4 second way filled
    '{4'd5,  1'b0, 1'b1, 1'b0, 24'h000012, 8'h00, 1'b1, 8'hAB, 4'd0, 4'd0}, // R5 written byte in cache
    '{4'd4,  1'b0, 1'b1, 1'b0, 24'h000030, 8'h00, 1'b1, 8'h30, 4'd1, 4'd0}, // R4 clean way replaced
    '{4'd6,  1'b0, 1'b1, 1'b0, 24'h000040, 8'h00, 1'b1, 8'h40, 4'd1, 4'd1}, // R6 modified victim out
    '{4'd6,  1'b0, 1'b1, 1'b0, 24'h000012, 8'h00, 1'b1, 8'hAB, 4'd1, 4'd0}, // R6 data came back
    '{4'd7,  1'b0, 1'b0, 1'b1, 24'h000013, 8'h5C, 1'b0, 8'h00, 4'd0, 4'd1}, // R7 write-through hit
    '{4'd8,  1'b0, 1'b0, 1'b1, 24'h000050, 8'h77, 1'b0, 8'h00, 4'd0, 4'd1}, // R8 no allocate
    '{4'd8,  1'b0, 1'b1, 1'b0, 24'h000050, 8'h00, 1'b1, 8'h77, 4'd1, 4'd0}, // R8 still a miss
    '{4'd9,  1'b0, 1'b1, 1'b1, 24'h000064, 8'h99, 1'b0, 8'h00, 4'd1, 4'd0}, // R9 allocate on write
    '{4'd10, 1'b1, 1'b1, 1'b0, 24'h000064, 8'h00, 1'b1, 8'h64, 4'd1, 4'd0}, // R10 bypass read
    '{4'd10, 1'b1, 1'b1, 1'b1, 24'h000068, 8'h11, 1'b0, 8'h00, 4'd0, 4'd1}, // R10 bypass write
    '{4'd10, 1'b0, 1'b1, 1'b0, 24'h000064, 8'h00, 1'b1, 8'h99, 4'd0, 4'd0}, // R10 line untouched
    '{4'd1,  1'b0, 1'b1, 1'b0, 24'h000068, 8'h00, 1'b1, 8'h11, 4'd1, 4'd0}, // R1 other set, fresh
    '{4'd7,  1'b0, 1'b1, 1'b0, 24'h000013, 8'h00, 1'b1, 8'h5C, 4'd0, 4'd0}, // R7 cache also updated
    '{4'd4,  1'b0, 1'b1, 1'b0, 24'h000020, 8'h00, 1'b1, 8'h20, 4'd1, 4'd0}  // R4 recency victim
  };

  logic              clk;
  logic              rst_n;
  logic              ctl_disable;
  logic              ctl_wback;
  logic              cpu_req;
  logic              cpu_we;
  logic [ADDR_W-1:0] cpu_addr;
  logic [7:0]        cpu_wdata;
  logic [7:0]        cpu_rdata;
  logic              cpu_ready;
  logic              mem_req;
  logic              mem_we;
  logic [BLK_W-1:0]  mem_addr;
  logic [BE_W-1:0]   mem_be;
  logic [LINE_W-1:0] mem_wdata;
  logic [LINE_W-1:0] mem_rdata;
  logic              mem_ready;

  int n_cmp;
  int n_err;
  int rd_cnt;
  int wr_cnt;
  int lat;
  logic [31:0] bmem [1024];

  cache_2way #(.ADDR_W(ADDR_W), .SETS_W(SETS_W), .OFFS_W(OFFS_W)) i_cache_2way (
    .clk(clk), .rst_n(rst_n), .ctl_disable(ctl_disable), .ctl_wback(ctl_wback),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Memory model: byte at address a starts as a[7:0].
  initial begin
    for (int i = 0; i < 1024; i++)
      bmem[i] = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)};
    mem_ready = 1'b0;
    mem_rdata = '0;
    lat       = 0;
    rd_cnt    = 0;
    wr_cnt    = 0;
  end

  always @(posedge clk) begin
    if (mem_ready) begin
      mem_ready <= 1'b0;
      lat       <= 0;
    end else if (mem_req) begin
      if (lat == LAT) begin
        mem_ready <= 1'b1;
        lat       <= 0;
        if (mem_we) begin
          for (int b = 0; b < BE_W; b++)
            if (mem_be[b]) bmem[mem_addr[9:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rdata <= bmem[mem_addr[9:0]];
          rd_cnt    <= rd_cnt + 1;
        end
      end else begin
        lat <= lat + 1;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic dis, input logic wb, input logic we, input logic [23:0] addr,
                        input logic [7:0] wd, output logic [7:0] rd, output int nr, output int nw);
    int r0;
    int w0;
    r0 = rd_cnt;
    w0 = wr_cnt;
    @(negedge clk);
    ctl_disable = dis;
    ctl_wback   = wb;
    cpu_we      = we;
    cpu_addr    = addr;
    cpu_wdata   = wd;
    cpu_req     = 1'b1;
    do @(negedge clk); while (!cpu_ready);
    rd      = cpu_rdata;
    cpu_req = 1'b0;
    nr      = rd_cnt - r0;
    nw      = wr_cnt - w0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int nr;
    int nw;
    n_cmp = 0;
    n_err = 0;
    rst_n = 1'b0;
    ctl_disable = 1'b0;
    ctl_wback   = 1'b1;
    cpu_req     = 1'b0;
    cpu_we      = 1'b0;
    cpu_addr    = '0;
    cpu_wdata   = '0;
    repeat (3) @(negedge clk);
    check("R12 reset cpu_ready", int'(cpu_ready), 0);
    check("R12 reset mem_req", int'(mem_req), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      access(VEC[v].dis, VEC[v].wb, VEC[v].we, VEC[v].addr, VEC[v].wdata, rd, nr, nw);
      if (VEC[v].chk) check($sformatf("R%0d vec %0d rdata", VEC[v].req, v), int'(rd), int'(VEC[v].exp_rd));
      check($sformatf("R%0d vec %0d mem reads", VEC[v].req, v), nr, int'(VEC[v].exp_r));
      check($sformatf("R%0d vec %0d mem writes", VEC[v].req, v), nw, int'(VEC[v].exp_w));
    end

    // R7: memory itself holds the write-through byte at its lane
    check("R7 memory byte", int'(bmem[10'h004][31:24]), 32'h5C);
    // R6: evicted modified byte reached memory
    check("R6 memory byte", int'(bmem[10'h004][23:16]), 32'hAB);

    // R11: reset in mid-run drops all lines, modified data included
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 reset cpu_ready", int'(cpu_ready), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b0, 1'b1, 1'b0, 24'h000064, 8'h00, rd, nr, nw);
    check("R11 miss after reset reads", nr, 1);
    check("R11 miss after reset writes", nw, 0);
    check("R11 stale line gone", int'(rd), 32'h64);
    access(1'b0, 1'b1, 1'b0, 24'h000013, 8'h00, rd, nr, nw);
    check("R11 second block misses", nr, 1);
    check("R11 memory copy", int'(rd), 32'h5C);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

endmodule